// File: doc/BRIEF.md
# Oversampled Serial Receiver with Four-Entry Buffer and Address Wake-Up

This block turns an asynchronous serial line into buffered characters. It runs from the core clock, and a one-cycle sample enable that pulses sixteen times per bit period paces it. A character begins with a low start bit. Then come 5 to 8 data bits, least significant first. An optional extra bit follows, and last comes a stop bit. The extra bit is a parity bit in normal operation and an address/data flag in multidrop operation. Each finished character goes into a four-entry first-in first-out store, together with its parity-error, framing-error and address flags. The oldest entry always appears on the read outputs, and a one-cycle read strobe removes it.

Around that store the block keeps sticky overrun and break-change indications and a live break indication. It also drives an active-low request-to-send output, which can release the remote transmitter while the store is full. In a multidrop network a station can put its receiver to sleep. While asleep, the receiver keeps only characters marked as addresses, and it wakes on command once software recognises its own address.

Top module: `uart_mdrop_rx`

## Requirements
- R1: After reset, rx_ready, fifo_full, overrun, brk_active and brk_change are 0, rts_n is 0 and the read outputs are all zero.
- R2: The line idles high. The receiver treats the first sample-enable tick that sees the line low as a start. It checks the start on the 8th tick after that, then samples one bit every 16 ticks, least significant bit first. cfg_bits selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, and rd_data bits above the width read 0.
- R3: With cfg_multidrop = 0, cfg_par selects the extra bit: 00 none (no extra bit), 01 even, 10 odd, 11 forced. rd_perr is set when data plus extra bit has an odd count of ones (even mode) or an even count (odd mode), or when the extra bit differs from cfg_force_val (forced mode). With no extra bit, rd_perr is 0.
- R4: A low stop sample on a character that is not a break sets rd_ferr for that character.
- R5: If the line is back high at the start check, the event is a false start and nothing is stored. This includes a short low after a low stop bit.
- R6: Up to four characters are stored and read in arrival order. rx_ready is 1 while at least one is stored, fifo_full is 1 while four are stored, and rd_strobe removes the head. While rx_ready is 0, the read outputs are zero.
- R7: A character that completes while four are stored and no read happens in that cycle is lost and sets overrun. Reads do not clear overrun. Only cmd_err_rst clears it, and a new overrun in the same cycle takes priority.
- R8: A low stop sample with all data and extra bits 0 is a break. No character is stored, and brk_active stays 1 until a tick sees the line high. The start and the end of a break each set brk_change, which cmd_err_rst clears.
- R9: A break that begins in the middle of a character first yields that character with rd_ferr set, and is then detected as a break.
- R10: With cfg_rts_auto = 1, rts_n is 1 in the cycle after fifo_full is 1 and 0 otherwise. With cfg_rts_auto = 0, rts_n is 0 in the next cycle.
- R11: With cfg_multidrop = 1, every character carries the extra bit as an address flag (1 = address), presented on rd_addr. No parity check is made then (rd_perr = 0, whatever cfg_par is).
- R12: cmd_sleep puts the receiver to sleep and cmd_wake wakes it. While asleep with cfg_multidrop = 1, characters whose flag is 0 are dropped and leave the store untouched. Address characters are stored. With cfg_multidrop = 0, sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit |
| rxd | input | 1 | Serial line input |
| cfg_bits | input | 2 | Data width code (5 + value bits) |
| cfg_par | input | 2 | Extra-bit mode: none, even, odd, forced |
| cfg_force_val | input | 1 | Expected extra bit in forced mode |
| cfg_multidrop | input | 1 | Extra bit is an address flag |
| cfg_rts_auto | input | 1 | Release rts_n while the store is full |
| cmd_sleep | input | 1 | Pulse: enter sleep |
| cmd_wake | input | 1 | Pulse: leave sleep |
| cmd_err_rst | input | 1 | Pulse: clear overrun and brk_change |
| rd_strobe | input | 1 | Pulse: remove head entry |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_addr | output | 1 | Head address flag |
| rx_ready | output | 1 | At least one character stored |
| fifo_full | output | 1 | Four characters stored |
| overrun | output | 1 | Sticky lost-character flag |
| brk_active | output | 1 | Break currently on the line |
| brk_change | output | 1 | Sticky break start/end flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The assertions check the cycle-level invariants on every cycle:
- rd_data and the flags are zero while the store is empty, and fifo_full implies rx_ready.
- rx_ready stays set unless a read happens.
- overrun and brk_change only fall after an error reset, and brk_change rises together with brk_active.
- rts_n follows fifo_full and cfg_rts_auto.

The bench scenarios are needed for what depends on serial timing and on data values:
- correct framing for every width and extra-bit mode, and the parity result;
- false-start rejection and framing errors;
- arrival order and loss of a fifth character;
- break detection, including a break that starts mid-character;
- address filtering while asleep.

// File: rtl/uart_mdrop_pkg.sv
package uart_mdrop_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_XBIT,
    FR_STOP,
    FR_BRK
  } fr_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_FORCE = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              addr;
  } rx_entry_t;

endpackage

// File: rtl/uart_mdrop_framer.sv
module uart_mdrop_framer
  import uart_mdrop_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_bits,
  input  logic              cfg_xbit,
  output logic              chr_vld,
  output logic [CHAR_W-1:0] chr_data,
  output logic              chr_xbit,
  output logic              chr_stop,
  output logic              brk_start,
  output logic              brk_end,
  output logic              brk_active
);

  localparam int unsigned CNT_W   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

  // input synchronizer, length chosen by parameter
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;

  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= rxd;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
  end

  assign rx_s = sync_q[SYNC_STAGES-1];

  fr_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              xb_q, xb_d;
  logic [2:0]        last_idx;

  assign last_idx = {1'b0, cfg_bits} + 3'd4;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    xb_d      = xb_q;
    chr_vld   = 1'b0;
    brk_start = 1'b0;
    brk_end   = 1'b0;
    if (tick) begin
      unique case (st_q)
        FR_IDLE: begin
          if (!rx_s) begin
            st_d  = FR_START;
            cnt_d = '0;
          end
        end
        FR_START: begin
          if (cnt_q == MID_LAST) begin
            if (rx_s) begin
              st_d = FR_IDLE;
            end else begin
              st_d  = FR_DATA;
              cnt_d = '0;
              idx_d = '0;
              sh_d  = '0;
              xb_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_DATA: begin
          if (cnt_q == BIT_LAST) begin
            cnt_d       = '0;
            sh_d[idx_q] = rx_s;
            if (idx_q == last_idx) st_d = cfg_xbit ? FR_XBIT : FR_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_XBIT: begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            xb_d  = rx_s;
            st_d  = FR_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_STOP: begin
          if (cnt_q == BIT_LAST) begin
            cnt_d = '0;
            if (!rx_s && (sh_q == '0) && !xb_q) begin
              st_d      = FR_BRK;
              brk_start = 1'b1;
            end else begin
              st_d    = FR_IDLE;
              chr_vld = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        FR_BRK: begin
          if (rx_s) begin
            st_d    = FR_IDLE;
            brk_end = 1'b1;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      xb_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      xb_q  <= xb_d;
    end
  end

  assign chr_data   = sh_q;
  assign chr_xbit   = xb_q;
  assign chr_stop   = rx_s;
  assign brk_active = (st_q == FR_BRK);

endmodule

// File: rtl/uart_mdrop_fifo.sv
module uart_mdrop_fifo
  import uart_mdrop_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t push_ent,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      ovf
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CNT_MAX) || do_pop);
    ovf     = push && !do_push;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_ent;
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
  assign head  = empty ? '0 : mem[rd_q];

endmodule

// File: rtl/uart_mdrop_status.sv
module uart_mdrop_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic brk_start,
  input  logic brk_end,
  input  logic err_rst,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic full,
  input  logic rts_auto,
  output logic overrun,
  output logic brk_change,
  output logic asleep,
  output logic rts_n
);

  logic ovr_q, ovr_d, chg_q, chg_d, slp_q, slp_d, rts_q, rts_d;

  always_comb begin
    ovr_d = ovr_q;
    chg_d = chg_q;
    slp_d = slp_q;
    if (err_rst) begin
      ovr_d = 1'b0;
      chg_d = 1'b0;
    end
    if (ovf_evt)               ovr_d = 1'b1;
    if (brk_start || brk_end)  chg_d = 1'b1;
    if (wake_req)              slp_d = 1'b0;
    if (sleep_req)             slp_d = 1'b1;
    rts_d = rts_auto && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      chg_q <= 1'b0;
      slp_q <= 1'b0;
      rts_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      chg_q <= chg_d;
      slp_q <= slp_d;
      rts_q <= rts_d;
    end
  end

  assign overrun    = ovr_q;
  assign brk_change = chg_q;
  assign asleep     = slp_q;
  assign rts_n      = rts_q;

endmodule

// File: rtl/uart_mdrop_rx.sv
module uart_mdrop_rx
  import uart_mdrop_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEPTH       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_bits,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_force_val,
  input  logic              cfg_multidrop,
  input  logic              cfg_rts_auto,
  input  logic              cmd_sleep,
  input  logic              cmd_wake,
  input  logic              cmd_err_rst,
  input  logic              rd_strobe,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_addr,
  output logic              rx_ready,
  output logic              fifo_full,
  output logic              overrun,
  output logic              brk_active,
  output logic              brk_change,
  output logic              rts_n
);

  logic              chr_vld, chr_xbit, chr_stop, brk_start, brk_end;
  logic [CHAR_W-1:0] chr_data;
  logic              has_xbit, asleep, accept, perr, ones_odd;
  logic              empty, ovf;
  rx_entry_t         ent, head;
  par_mode_e         pmode;

  assign pmode    = par_mode_e'(cfg_par);
  assign has_xbit = cfg_multidrop || (pmode != PAR_NONE);

  uart_mdrop_framer #(
    .OSR         (OSR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rxd        (rxd),
    .cfg_bits   (cfg_bits),
    .cfg_xbit   (has_xbit),
    .chr_vld    (chr_vld),
    .chr_data   (chr_data),
    .chr_xbit   (chr_xbit),
    .chr_stop   (chr_stop),
    .brk_start  (brk_start),
    .brk_end    (brk_end),
    .brk_active (brk_active)
  );

  always_comb begin
    ones_odd = (^chr_data) ^ chr_xbit;
    unique case (pmode)
      PAR_EVEN:  perr = ones_odd;
      PAR_ODD:   perr = !ones_odd;
      PAR_FORCE: perr = (chr_xbit != cfg_force_val);
      default:   perr = 1'b0;
    endcase
    if (cfg_multidrop) perr = 1'b0;
    ent.data = chr_data;
    ent.perr = perr;
    ent.ferr = !chr_stop;
    ent.addr = cfg_multidrop && chr_xbit;
    accept   = chr_vld && !(cfg_multidrop && asleep && !chr_xbit);
  end

  uart_mdrop_fifo #(
    .DEPTH (DEPTH)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_ent (ent),
    .pop      (rd_strobe),
    .head     (head),
    .empty    (empty),
    .full     (fifo_full),
    .ovf      (ovf)
  );

  uart_mdrop_status u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_evt    (ovf),
    .brk_start  (brk_start),
    .brk_end    (brk_end),
    .err_rst    (cmd_err_rst),
    .sleep_req  (cmd_sleep),
    .wake_req   (cmd_wake),
    .full       (fifo_full),
    .rts_auto   (cfg_rts_auto),
    .overrun    (overrun),
    .brk_change (brk_change),
    .asleep     (asleep),
    .rts_n      (rts_n)
  );

  assign rx_ready = !empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_addr  = head.addr;

endmodule

// File: rtl/uart_mdrop_rx_chk.sv
module uart_mdrop_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rts_auto,
  input logic       cmd_err_rst,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       rd_perr,
  input logic       rd_ferr,
  input logic       rd_addr,
  input logic       rx_ready,
  input logic       fifo_full,
  input logic       overrun,
  input logic       brk_active,
  input logic       brk_change,
  input logic       rts_n
);

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (rd_data == 8'h00 && !rd_perr && !rd_ferr && !rd_addr)); // R6

  AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_ready); // R6

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rd_strobe) |=> rx_ready); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(cmd_err_rst)); // R7

  AST_BRKCHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_change) |-> $past(cmd_err_rst)); // R8

  AST_BRK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_active) |-> brk_change); // R8

  AST_BRK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !rx_ready) |=> !rx_ready); // R8

  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rts_auto && fifo_full) |=> rts_n); // R10

  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rts_auto |=> !rts_n); // R10

endmodule

bind uart_mdrop_rx uart_mdrop_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rts_auto (cfg_rts_auto),
  .cmd_err_rst  (cmd_err_rst),
  .rd_strobe    (rd_strobe),
  .rd_data      (rd_data),
  .rd_perr      (rd_perr),
  .rd_ferr      (rd_ferr),
  .rd_addr      (rd_addr),
  .rx_ready     (rx_ready),
  .fifo_full    (fifo_full),
  .overrun      (overrun),
  .brk_active   (brk_active),
  .brk_change   (brk_change),
  .rts_n        (rts_n)
);

// File: tb/uart_mdrop_rx_bench.sv
`timescale 1ns/1ps
module uart_mdrop_rx_bench;

  localparam int BIT_CYC = 32; // 16 ticks, one tick every 2 cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_bits = 2'b11;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_force_val = 1'b0;
  logic       cfg_multidrop = 1'b0;
  logic       cfg_rts_auto = 1'b1;
  logic       cmd_sleep = 1'b0;
  logic       cmd_wake = 1'b0;
  logic       cmd_err_rst = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_addr, rx_ready, fifo_full;
  logic       overrun, brk_active, brk_change, rts_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick16 <= 1'b0;
    else        tick16 <= ~tick16;
  end

  uart_mdrop_rx u_uart_mdrop_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick16        (tick16),
    .rxd           (rxd),
    .cfg_bits      (cfg_bits),
    .cfg_par       (cfg_par),
    .cfg_force_val (cfg_force_val),
    .cfg_multidrop (cfg_multidrop),
    .cfg_rts_auto  (cfg_rts_auto),
    .cmd_sleep     (cmd_sleep),
    .cmd_wake      (cmd_wake),
    .cmd_err_rst   (cmd_err_rst),
    .rd_strobe     (rd_strobe),
    .rd_data       (rd_data),
    .rd_perr       (rd_perr),
    .rd_ferr       (rd_ferr),
    .rd_addr       (rd_addr),
    .rx_ready      (rx_ready),
    .fifo_full     (fifo_full),
    .overrun       (overrun),
    .brk_active    (brk_active),
    .brk_change    (brk_change),
    .rts_n         (rts_n)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input bit has_x,
                           input bit xb, input bit stop_hi);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (has_x) drive_bit(xb);
    if (stop_hi) begin
      drive_bit(1'b1);
    end else begin
      rxd = 1'b0;
      repeat (24) @(negedge clk);
      rxd = 1'b1;
      repeat (8) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
  endtask

  task automatic pop();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: cmd_err_rst = 1'b1;
      1: cmd_sleep   = 1'b1;
      default: cmd_wake = 1'b1;
    endcase
    @(negedge clk);
    cmd_err_rst = 1'b0;
    cmd_sleep   = 1'b0;
    cmd_wake    = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_expect(input string req, input int d, input int pe,
                             input int fe, input int ad);
    check_eq(req, "rx_ready", int'(rx_ready), 1);
    check_eq(req, "rd_data", int'(rd_data), d);
    check_eq(req, "rd_perr", int'(rd_perr), pe);
    check_eq(req, "rd_ferr", int'(rd_ferr), fe);
    check_eq(req, "rd_addr", int'(rd_addr), ad);
    pop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [4];
    vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'hFF; vals[3] = 8'h01;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq("R1", "rx_ready", int'(rx_ready), 0);
    check_eq("R1", "fifo_full", int'(fifo_full), 0);
    check_eq("R1", "overrun", int'(overrun), 0);
    check_eq("R1", "brk_active", int'(brk_active), 0);
    check_eq("R1", "brk_change", int'(brk_change), 0);
    check_eq("R1", "rts_n", int'(rts_n), 0);
    check_eq("R1", "rd_data", int'(rd_data), 0);

    // R2 / R3 sweep: every width, every extra-bit mode, several patterns
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 4; pm++) begin
        for (int k = 0; k < 4; k++) begin
          int         nb;
          logic [7:0] mask, v;
          logic       p, fv, ep;
          nb   = w + 5;
          mask = 8'((1 << nb) - 1);
          v    = vals[k] & mask;
          p    = logic'(k % 2) ^ logic'(w % 2);
          fv   = logic'(k / 2);
          case (pm)
            1: ep = (^v) ^ p;
            2: ep = ~((^v) ^ p);
            3: ep = (p != fv);
            default: ep = 1'b0;
          endcase
          cfg_bits      = 2'(w);
          cfg_par       = 2'(pm);
          cfg_force_val = fv;
          @(negedge clk);
          send_char(v, nb, pm != 0, p, 1'b1);
          read_expect(pm == 0 ? "R2" : "R3", int'(v), int'(ep), 0, 0);
        end
      end
    end

    // R4 framing error, then R5 short low after low stop rejected
    cfg_bits = 2'b11; cfg_par = 2'b00;
    @(negedge clk);
    send_char(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    read_expect("R4", 'h5A, 0, 1, 0);
    repeat (12 * BIT_CYC) @(negedge clk);
    check_eq("R5", "rx_ready after low stop", int'(rx_ready), 0);

    // R5 false start: line low for less than half a bit
    rxd = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b1;
    repeat (14 * BIT_CYC) @(negedge clk);
    check_eq("R5", "rx_ready after glitch", int'(rx_ready), 0);

    // R6 / R7 / R10 fill, overrun, order, rts
    for (int n = 1; n <= 5; n++) begin
      send_char(8'(n * 17), 8, 1'b0, 1'b0, 1'b1);
      if (n == 3) begin
        check_eq("R6", "fifo_full at 3", int'(fifo_full), 0);
        check_eq("R10", "rts_n at 3", int'(rts_n), 0);
      end
      if (n == 4) begin
        check_eq("R6", "fifo_full at 4", int'(fifo_full), 1);
        check_eq("R10", "rts_n at 4", int'(rts_n), 1);
        check_eq("R7", "overrun at 4", int'(overrun), 0);
      end
    end
    check_eq("R7", "overrun at 5", int'(overrun), 1);
    cfg_rts_auto = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R10", "rts_n manual", int'(rts_n), 0);
    cfg_rts_auto = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R10", "rts_n auto again", int'(rts_n), 1);
    for (int n = 1; n <= 4; n++) begin
      read_expect("R6", n * 17, 0, 0, 0);
      if (n == 1) check_eq("R10", "rts_n after read", int'(rts_n), 0);
    end
    check_eq("R6", "rx_ready drained", int'(rx_ready), 0);
    check_eq("R7", "overrun after reads", int'(overrun), 1);
    pulse(0);
    check_eq("R7", "overrun after err_rst", int'(overrun), 0);

    // R8 break from idle
    rxd = 1'b0;
    repeat (12 * BIT_CYC) @(negedge clk);
    check_eq("R8", "brk_active", int'(brk_active), 1);
    check_eq("R8", "brk_change on start", int'(brk_change), 1);
    check_eq("R8", "no char stored", int'(rx_ready), 0);
    pulse(0);
    check_eq("R8", "brk_change cleared", int'(brk_change), 0);
    check_eq("R8", "brk_active held", int'(brk_active), 1);
    rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    check_eq("R8", "brk_active ended", int'(brk_active), 0);
    check_eq("R8", "brk_change on end", int'(brk_change), 1);
    check_eq("R8", "rx_ready after break", int'(rx_ready), 0);
    pulse(0);

    // R9 break that starts in the middle of a character
    drive_bit(1'b0);
    drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
    rxd = 1'b0;
    repeat (18 * BIT_CYC) @(negedge clk);
    check_eq("R9", "brk_active mid", int'(brk_active), 1);
    repeat (2 * BIT_CYC) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    check_eq("R9", "brk_active end", int'(brk_active), 0);
    check_eq("R9", "brk_change", int'(brk_change), 1);
    read_expect("R9", 'h07, 0, 1, 0);
    check_eq("R9", "only one char", int'(rx_ready), 0);
    pulse(0);

    // R11 / R12 multidrop address filtering
    cfg_multidrop = 1'b1;
    cfg_par = 2'b00;
    @(negedge clk);
    pulse(1);
    send_char(8'h33, 8, 1'b1, 1'b0, 1'b1);
    check_eq("R12", "data dropped asleep", int'(rx_ready), 0);
    send_char(8'h42, 8, 1'b1, 1'b1, 1'b1);
    read_expect("R12", 'h42, 0, 0, 1);
    send_char(8'h24, 8, 1'b1, 1'b0, 1'b1);
    check_eq("R12", "still asleep", int'(rx_ready), 0);
    pulse(2);
    send_char(8'h5A, 8, 1'b1, 1'b0, 1'b1);
    read_expect("R11", 'h5A, 0, 0, 0);
    cfg_par = 2'b01;
    @(negedge clk);
    send_char(8'h01, 8, 1'b1, 1'b0, 1'b1);
    read_expect("R11", 'h01, 0, 0, 0);
    cfg_par = 2'b00;
    cfg_multidrop = 1'b0;
    @(negedge clk);
    pulse(1);
    send_char(8'h66, 8, 1'b0, 1'b0, 1'b1);
    read_expect("R12", 'h66, 0, 0, 0);
    pulse(2);

    done = 1'b1;
    report();
    $finish;
  end

endmodule